// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a small accumulator processor. A 3-bit step counter walks through the micro-steps of the instruction held in the instruction register. In every cycle the block joins the 5-bit opcode, the carry and zero flags already latched by the datapath, and the current step into a 10-bit microcode address. It then drives a 20-bit control word taken from a table built as constant combinational logic.

Every defined instruction starts with the same two fetch steps. Its own body follows, and then a word whose only set bit is bit 4, which means "instruction done". Because the flags are part of the table address, each conditional branch simply reads a different row of the table, and the datapath needs no branch logic. Bit 15 is the halt strobe. While the halt strobe is present the step counter stands still.

Top module: `ucode_sequencer`

## Requirements
- R1: While `rst` is high the step counter is forced to 0. After release, a defined opcode (0x00 to 0x12) shows 0x00104 on `ctrl` in the first cycle.
- R2: For every defined opcode, step 0 drives 0x00104 and step 1 drives 0x00068.
- R3: In the cycle after `ctrl` equals 0x00010 (bit 4, instruction done), the counter is at step 0, so a defined opcode shows 0x00104 again.
- R4: These bodies follow the fetch steps, and each ends with 0x00010:
  - NOP 0x00: no body words.
  - LDA immediate 0x02: 0x0010C, 0x04040.
  - STA 0x04: 0x0010C, 0x00140, 0x02080.
  - ADD from memory 0x09: 0x0010C, 0x00140, 0x00440, 0x15000.
  - SUB immediate 0x0A: 0x0010C, 0x00C40, 0x15800.
  - output A 0x0C: 0x02001.
- R5: The zero-branch 0x11 with `zero`=0, and the carry-branch 0x12 with `carry`=0, take the body 0x00008 and then 0x00010.
- R6: The zero-branch with `zero`=1, and the carry-branch with `carry`=1, take the body 0x0010C, 0x00042 and then 0x00010.
- R7: Opcodes other than 0x11 and 0x12 give the same word sequence for every combination of `carry` and `zero`.
- R8: Undefined opcodes (0x13 to 0x1F) drive 0x00000 on `ctrl` at every step.
- R9: If step 7 is reached without the done bit, the counter wraps to 0. With an undefined opcode held for 9 cycles after reset, the counter stands at step 1.
- R10: HALT (0x01) drives 0x08000 at step 2. The counter then holds, so `ctrl` keeps 0x08000 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 5 | Opcode from the instruction register |
| carry | input | 1 | Latched carry flag |
| zero | input | 1 | Latched zero flag |
| ctrl | output | 20 | Control word for the current step |

## Verification
`ctrl` depends combinationally on the inputs and on the step register. A new opcode or flag value therefore shows on `ctrl` in the same cycle, and a step advance shows one rising edge later. The bench changes its inputs on the falling edge and reads `ctrl` 1 ns later, so each sample shows exactly one step with no race against the counter update. Each scenario starts from a fresh reset and compares the words step by step against a list written from the requirements. It then checks that the fetch word reappears after the done word. The wrap and the halt are observed at the ports: the bench switches to a defined opcode after a chosen number of cycles, or keeps HALT applied for a long run.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
  parameter int OP_W   = 5;
  parameter int STEP_W = 3;
  parameter int CTRL_W = 20;
  localparam int BODY_N = (1 << STEP_W) - 2;

  localparam int END_BIT  = 4;
  localparam int HALT_BIT = 15;

  localparam logic [OP_W-1:0] OP_LAST = OP_W'(18);
  localparam logic [OP_W-1:0] OP_JZ   = OP_W'(17);
  localparam logic [OP_W-1:0] OP_JC   = OP_W'(18);

  localparam logic [CTRL_W-1:0] W_FETCH0 = CTRL_W'(20'h00104);
  localparam logic [CTRL_W-1:0] W_FETCH1 = CTRL_W'(20'h00068);
  localparam logic [CTRL_W-1:0] W_DONE   = CTRL_W'(20'h00010);
  localparam logic [CTRL_W-1:0] W_HALT   = CTRL_W'(20'h08000);
  localparam logic [CTRL_W-1:0] W_ARG    = CTRL_W'(20'h0010C);
  localparam logic [CTRL_W-1:0] W_MADR   = CTRL_W'(20'h00140);

  typedef struct packed {
    logic endInst;
    logic holdStep;
  } strobe_t;

  function automatic logic [CTRL_W-1:0] lookupWord(
      input logic [OP_W-1:0] op, input logic cFlag, input logic zFlag,
      input logic [STEP_W-1:0] step);
    logic [BODY_N-1:0][CTRL_W-1:0] body;
    logic taken;
    int idx;
    body  = '0;
    taken = (op == OP_JZ) ? zFlag : cFlag;
    idx   = int'(step) - 2;
    case (op)
      5'h00: body[0] = W_DONE;
      5'h01: begin body[0] = W_HALT; body[1] = W_DONE; end
      5'h02: begin body[0] = W_ARG; body[1] = 20'h04040; body[2] = W_DONE; end
      5'h03: begin body[0] = W_ARG; body[1] = W_MADR; body[2] = 20'h04040; body[3] = W_DONE; end
      5'h04: begin body[0] = W_ARG; body[1] = W_MADR; body[2] = 20'h02080; body[3] = W_DONE; end
      5'h05: begin body[0] = W_ARG; body[1] = 20'h00440; body[2] = W_DONE; end
      5'h06: begin body[0] = W_ARG; body[1] = W_MADR; body[2] = 20'h00440; body[3] = W_DONE; end
      5'h07: begin body[0] = W_ARG; body[1] = W_MADR; body[2] = 20'h00280; body[3] = W_DONE; end
      5'h08: begin body[0] = W_ARG; body[1] = 20'h00440; body[2] = 20'h15000; body[3] = W_DONE; end
      5'h09: begin
        body[0] = W_ARG; body[1] = W_MADR; body[2] = 20'h00440;
        body[3] = 20'h15000; body[4] = W_DONE;
      end
      5'h0A: begin body[0] = W_ARG; body[1] = 20'h00C40; body[2] = 20'h15800; body[3] = W_DONE; end
      5'h0B: begin
        body[0] = W_ARG; body[1] = W_MADR; body[2] = 20'h00C40;
        body[3] = 20'h15800; body[4] = W_DONE;
      end
      5'h0C: begin body[0] = 20'h02001; body[1] = W_DONE; end
      5'h0D: begin body[0] = 20'h00201; body[1] = W_DONE; end
      5'h0E: begin body[0] = W_ARG; body[1] = 20'h00041; body[2] = W_DONE; end
      5'h0F: begin body[0] = W_ARG; body[1] = W_MADR; body[2] = 20'h00041; body[3] = W_DONE; end
      5'h10: begin body[0] = W_ARG; body[1] = 20'h00042; body[2] = W_DONE; end
      5'h11, 5'h12: begin
        if (taken) begin body[0] = W_ARG; body[1] = 20'h00042; body[2] = W_DONE; end
        else begin body[0] = 20'h00008; body[1] = W_DONE; end
      end
      default: body = '0;
    endcase
    if (op > OP_LAST) return '0;
    if (idx == -2) return W_FETCH0;
    if (idx == -1) return W_FETCH1;
    if (idx < BODY_N) return body[idx];
    return '0;
  endfunction
endpackage

// File: rtl/ucode_table.sv
module ucode_table
  import ucode_pkg::*;
(
  input  logic [OP_W-1:0]   opcode,
  input  logic              carry,
  input  logic              zero,
  input  logic [STEP_W-1:0] step,
  output logic [CTRL_W-1:0] ctrlWord,
  output strobe_t           strobes
);
  always_comb begin
    ctrlWord         = lookupWord(opcode, carry, zero, step);
    strobes.endInst  = ctrlWord[END_BIT];
    strobes.holdStep = ctrlWord[HALT_BIT];
  end
endmodule

// File: rtl/ucode_step_ctrl.sv
module ucode_step_ctrl
  import ucode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobes,
  output logic [STEP_W-1:0] step
);
  localparam logic [STEP_W-1:0] STEP_LAST = '1;
  logic [STEP_W-1:0] stepNext;

  always_comb begin
    if (strobes.holdStep)       stepNext = step;
    else if (strobes.endInst)   stepNext = '0;
    else if (step == STEP_LAST) stepNext = '0;
    else                        stepNext = step + STEP_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) step <= '0;
    else     step <= stepNext;
  end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import ucode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opcode,
  input  logic              carry,
  input  logic              zero,
  output logic [CTRL_W-1:0] ctrl
);
  logic [STEP_W-1:0] step;
  strobe_t           strobes;

  ucode_step_ctrl u_step (
    .clk(clk), .rst(rst), .strobes(strobes), .step(step)
  );

  ucode_table u_table (
    .opcode(opcode), .carry(carry), .zero(zero), .step(step),
    .ctrlWord(ctrl), .strobes(strobes)
  );
endmodule

// File: rtl/ucode_sequencer_chk.sv
module ucode_sequencer_chk
  import ucode_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   opcode,
  input logic              carry,
  input logic              zero,
  input logic [CTRL_W-1:0] ctrl
);
  // R2
  fetch_order_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl == W_FETCH0 && opcode <= OP_LAST) |=> (opcode > OP_LAST || ctrl == W_FETCH1));

  // R3
  done_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl == W_DONE) |=> (opcode > OP_LAST || ctrl == W_FETCH0));

  // R8
  undefined_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode > OP_LAST) |-> (ctrl == '0));

  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl == W_HALT) |=> (!$stable(opcode) || ctrl == W_HALT));

  // R5
  branch_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl == CTRL_W'(20'h00008)) |=> ($changed(opcode) || ctrl == W_DONE));
endmodule

bind ucode_sequencer ucode_sequencer_chk chk (
  .clk(clk), .rst(rst), .opcode(opcode), .carry(carry), .zero(zero), .ctrl(ctrl)
);

// File: tb/tb_ucode_sequencer.sv
module tb_ucode_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  opcode = 5'h00;
  logic        carry = 1'b0;
  logic        zero = 1'b0;
  logic [19:0] ctrl;
  int          nRun = 0;
  int          nFail = 0;

  ucode_sequencer dut (
    .clk(clk), .rst(rst), .opcode(opcode), .carry(carry), .zero(zero), .ctrl(ctrl)
  );

  always #2.5 clk = ~clk;

  task automatic checkWord(input logic [19:0] expv, input string tag);
    nRun++;
    if (ctrl !== expv) begin
      nFail++;
      $display("FAIL %s: ctrl=%05h expected=%05h", tag, ctrl, expv);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic runSeq(input logic [4:0] op, input logic c, input logic z,
                        input logic [19:0] w[8], input int n, input string tag);
    opcode = op; carry = c; zero = z;
    doReset();
    for (int i = 0; i < n; i++) begin
      #1 checkWord(w[i], tag);
      @(negedge clk);
    end
    #1 checkWord(20'h00104, "R3 restart after done");
    @(negedge clk);
  endtask

  task automatic testReset();
    opcode = 5'h09; carry = 1'b0; zero = 1'b0;
    doReset();
    #1 checkWord(20'h00104, "R1 reset step");
    @(negedge clk);
  endtask

  task automatic testUndefined();
    opcode = 5'h15;
    doReset();
    for (int i = 0; i < 10; i++) begin
      #1 checkWord(20'h00000, "R8 undefined opcode");
      @(negedge clk);
    end
  endtask

  task automatic testWrap();
    opcode = 5'h1F;
    doReset();
    repeat (9) @(negedge clk);
    opcode = 5'h00;
    #1 checkWord(20'h00068, "R9 wrap to step 1");
    @(negedge clk);
  endtask

  task automatic testHalt();
    opcode = 5'h01;
    doReset();
    #1 checkWord(20'h00104, "R10 halt fetch0");
    @(negedge clk);
    #1 checkWord(20'h00068, "R10 halt fetch1");
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      #1 checkWord(20'h08000, "R10 halt hold");
      @(negedge clk);
    end
    doReset();
    #1 checkWord(20'h00104, "R10 reset leaves halt");
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    nFail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    testReset();
    runSeq(5'h00, 0, 0, '{20'h00104, 20'h00068, 20'h00010, 0, 0, 0, 0, 0}, 3, "R2 NOP");
    runSeq(5'h09, 0, 0, '{20'h00104, 20'h00068, 20'h0010C, 20'h00140, 20'h00440,
                          20'h15000, 20'h00010, 0}, 7, "R4 ADD mem c0z0");
    runSeq(5'h09, 1, 1, '{20'h00104, 20'h00068, 20'h0010C, 20'h00140, 20'h00440,
                          20'h15000, 20'h00010, 0}, 7, "R7 ADD mem c1z1");
    runSeq(5'h0A, 1, 0, '{20'h00104, 20'h00068, 20'h0010C, 20'h00C40, 20'h15800,
                          20'h00010, 0, 0}, 6, "R4 SUB imm");
    runSeq(5'h02, 0, 1, '{20'h00104, 20'h00068, 20'h0010C, 20'h04040, 20'h00010,
                          0, 0, 0}, 5, "R7 LDA imm c0z1");
    runSeq(5'h04, 0, 0, '{20'h00104, 20'h00068, 20'h0010C, 20'h00140, 20'h02080,
                          20'h00010, 0, 0}, 6, "R4 STA");
    runSeq(5'h0C, 1, 1, '{20'h00104, 20'h00068, 20'h02001, 20'h00010, 0, 0, 0, 0},
           4, "R4 OUT A");
    runSeq(5'h11, 1, 0, '{20'h00104, 20'h00068, 20'h00008, 20'h00010, 0, 0, 0, 0},
           4, "R5 zero-branch not taken");
    runSeq(5'h11, 0, 1, '{20'h00104, 20'h00068, 20'h0010C, 20'h00042, 20'h00010,
                          0, 0, 0}, 5, "R6 zero-branch taken");
    runSeq(5'h12, 0, 1, '{20'h00104, 20'h00068, 20'h00008, 20'h00010, 0, 0, 0, 0},
           4, "R5 carry-branch not taken");
    runSeq(5'h12, 1, 0, '{20'h00104, 20'h00068, 20'h0010C, 20'h00042, 20'h00010,
                          0, 0, 0}, 5, "R6 carry-branch taken");
    testUndefined();
    testWrap();
    testHalt();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule